// File: doc/BRIEF.md
# Floating-Point Load Widener (single/double to 80-bit extended)

This block takes a single-precision (32-bit) or double-precision (64-bit) floating-point operand, as it arrives from memory in little-endian byte order, and rewrites it in the 80-bit extended register format. That format has a sign bit, a 15-bit exponent biased by 16383, and a 64-bit significand whose integer bit is explicit. The block rebiases the exponent and makes the hidden integer bit visible. It passes zeros, infinities and NaNs through with their own encodings, and quiets signaling NaNs.

Denormal sources get special handling. When the denormal exception is masked, a left shifter moves the significand one bit per clock, and lowers the exponent by one each step, until the integer bit is 1. The result is a normalized extended value. When the exception is unmasked, the block returns at once with the denormal flag raised and the result marked as not to be committed.

Operands enter on a valid/ready channel and results leave on a second valid/ready channel. Only one operation is in flight at a time. `in_ready` is high only while the block is idle with no result pending. A result is held, unchanged, on `out_valid` until `out_ready` takes it. The input channel stays closed until then.

Top module: `fp_ext_loader`

## Requirements
- R1: A single-precision operand is read as sign = word bit 31, exponent = bits 30:23, fraction = bits 22:0. A normal value (exponent 1..254) gives extended sign = same, exponent = e - 127 + 16383, significand bit 63 = 1, and the fraction in significand bits 62:40 with the bits below cleared.
- R2: A double-precision operand is read as sign = bit 63, exponent = bits 62:52, fraction = bits 51:0. A normal value (exponent 1..2046) gives exponent = e - 1023 + 16383, significand bit 63 = 1, and the fraction in significand bits 62:11.
- R3: Byte lane k of `in_mem` (bits 8k+7:8k) is the byte at address base+k, so the word is assembled least significant byte first. With `in_dbl` = 0 only lanes 0..3 are used, and the contents of lanes 4..7 have no effect on any output.
- R4: A zero source (exponent and fraction all 0) gives extended exponent 0 and significand 0, and keeps the sign.
- R5: An all-ones source exponent gives extended exponent 7FFF with significand bit 63 = 1 and the fraction left-aligned below it. With fraction 0 (infinity) or top fraction bit 1 (quiet NaN), `out_invalid` is 0.
- R6: A signaling NaN (all-ones exponent, nonzero fraction, top fraction bit 0) sets `out_invalid` and is delivered quieted: significand bit 62 is set and the rest of the fraction is kept.
- R7: With `in_dnorm_mask` = 1, a denormal source (exponent 0, fraction nonzero, fraction msb at position p of an F-bit fraction) is normalized. Its significand is shifted by n = F - p to put a 1 in bit 63, its exponent is 16383 - (bias - 1) - n, and `out_valid` rises n + 1 cycles after the accepting edge.
- R8: With `in_dnorm_mask` = 0, a denormal source returns one cycle after acceptance with `out_commit` = 0. The value is left unnormalized: exponent 16383 - (bias - 1), integer bit 0, and the fraction left-aligned.
- R9: `out_denormal` is 1 for every denormal source whatever the mask. It is 0 for every other class. `out_commit` is 1 for everything except an unmasked denormal.
- R10: `in_ready` is high only when no operation is in progress or pending. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and the output value and flags stay unchanged.
- R11: Every result except a masked denormal becomes valid one cycle after the accepting edge. On the edge where `out_valid` and `out_ready` are both high, `out_valid` drops and `in_ready` rises.
- R12: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Block idle and able to take an operand |
| in_dbl | input | 1 | 1 = double precision, 0 = single precision |
| in_mem | input | 64 | Operand bytes, lane k = address base+k |
| in_dnorm_mask | input | 1 | 1 = denormal exception masked (normalize) |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_value | output | 80 | Extended result: sign 79, exponent 78:64, significand 63:0 |
| out_invalid | output | 1 | Invalid-operation flag (signaling NaN source) |
| out_denormal | output | 1 | Denormal-operand flag |
| out_commit | output | 1 | 0 = result must not be written back |

## Verification
Most results appear one cycle after the edge on which `in_valid` and `in_ready` are both high. A masked denormal instead appears after n + 1 cycles, where n is the normalization distance that the bench computes from the position of the fraction's leading one. After each accepting edge, the bench counts falling edges until `out_valid` is seen and compares that count with the expected latency. Values and flags are sampled at the same falling edge. Stalled vectors hold `out_ready` low for several cycles and recheck that the output does not change. They then confirm that the output clears and `in_ready` returns one cycle after release.

// File: rtl/fpx_pkg.sv
`timescale 1ns/1ps
package fpx_pkg;
  localparam int XEXP_W   = 15;
  localparam int XSIG_W   = 64;
  localparam int XW       = 1 + XEXP_W + XSIG_W;
  localparam int XBIAS    = (1 << (XEXP_W - 1)) - 1;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_FRAC_W = 23;
  localparam int DBL_EXP_W  = 11;
  localparam int DBL_FRAC_W = 52;
  localparam int SGL_W    = 1 + SGL_EXP_W + SGL_FRAC_W;
  localparam int DBL_W    = 1 + DBL_EXP_W + DBL_FRAC_W;
  localparam int LANES    = DBL_W / 8;

  typedef enum logic [2:0] {
    C_ZERO, C_NORM, C_DEN, C_INF, C_QNAN, C_SNAN
  } fcls_e;

  typedef struct packed {
    logic              sign;
    fcls_e             cls;
    logic [XEXP_W-1:0] exp;
    logic [XSIG_W-1:0] sig;
  } xform_t;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_HOLD} lstate_e;
endpackage

// File: rtl/fpx_unpack.sv
`timescale 1ns/1ps
module fpx_unpack
  import fpx_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output xform_t                form
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int OFF  = XBIAS - BIAS;
  localparam int PAD  = XSIG_W - 1 - FRAC_W;

  logic [EXP_W-1:0]  e;
  logic [FRAC_W-1:0] f;
  logic              e_zero, e_max, f_zero;

  assign e      = word[EXP_W+FRAC_W-1:FRAC_W];
  assign f      = word[FRAC_W-1:0];
  assign e_zero = (e == '0);
  assign e_max  = (e == '1);
  assign f_zero = (f == '0);

  always_comb begin
    form.sign = word[EXP_W+FRAC_W];
    form.cls  = C_NORM;
    form.exp  = XEXP_W'(e) + XEXP_W'(OFF);
    form.sig  = {1'b1, f, {PAD{1'b0}}};
    if (e_zero) begin
      if (f_zero) begin
        form.cls = C_ZERO;
        form.exp = '0;
        form.sig = '0;
      end else begin
        form.cls = C_DEN;
        form.exp = XEXP_W'(OFF + 1);
        form.sig = {1'b0, f, {PAD{1'b0}}};
      end
    end else if (e_max) begin
      form.exp = '1;
      if (f_zero) begin
        form.cls = C_INF;
        form.sig = {1'b1, {(XSIG_W-1){1'b0}}};
      end else begin
        form.cls = f[FRAC_W-1] ? C_QNAN : C_SNAN;
        form.sig = {2'b11, f[FRAC_W-2:0], {PAD{1'b0}}};
      end
    end
  end
endmodule

// File: rtl/fpx_shift.sv
`timescale 1ns/1ps
module fpx_shift
  import fpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [XEXP_W-1:0] load_exp,
  input  logic [XSIG_W-1:0] load_sig,
  input  logic              step,
  output logic [XEXP_W-1:0] exp_q,
  output logic [XSIG_W-1:0] sig_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= '0;
      sig_q <= '0;
    end else if (load) begin
      exp_q <= load_exp;
      sig_q <= load_sig;
    end else if (step) begin
      exp_q <= exp_q - 1'b1;
      sig_q <= {sig_q[XSIG_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/fp_ext_loader.sv
`timescale 1ns/1ps
module fp_ext_loader
  import fpx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_dbl,
  input  logic [8*LANES-1:0] in_mem,
  input  logic            in_dnorm_mask,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XW-1:0]   out_value,
  output logic            out_invalid,
  output logic            out_denormal,
  output logic            out_commit
);
  logic [DBL_W-1:0] word;
  xform_t f_sgl, f_dbl, sel;
  lstate_e state;
  logic accept, den_src, go_shift, step;
  logic sign_q, inv_q, den_q, commit_q;
  logic [XEXP_W-1:0] exp_q;
  logic [XSIG_W-1:0] sig_q;

  // little-endian assembly: lane k is the byte at base address + k
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign word[8*k +: 8] = in_mem[8*k +: 8];
  end

  fpx_unpack #(.EXP_W(SGL_EXP_W), .FRAC_W(SGL_FRAC_W)) u_sgl (
    .word(word[SGL_W-1:0]), .form(f_sgl));
  fpx_unpack #(.EXP_W(DBL_EXP_W), .FRAC_W(DBL_FRAC_W)) u_dbl (
    .word(word), .form(f_dbl));

  assign sel      = in_dbl ? f_dbl : f_sgl;
  assign in_ready = (state == S_IDLE);
  assign accept   = in_valid && in_ready;
  assign den_src  = (sel.cls == C_DEN);
  assign go_shift = den_src && in_dnorm_mask;
  assign step     = (state == S_SHIFT);

  fpx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_exp(sel.exp),
    .load_sig(sel.sig), .step(step), .exp_q(exp_q), .sig_q(sig_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      sign_q   <= 1'b0;
      inv_q    <= 1'b0;
      den_q    <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          sign_q   <= sel.sign;
          inv_q    <= (sel.cls == C_SNAN);
          den_q    <= den_src;
          commit_q <= !(den_src && !in_dnorm_mask);
          state    <= go_shift ? S_SHIFT : S_HOLD;
        end
        S_SHIFT: if (sig_q[XSIG_W-2]) state <= S_HOLD;
        S_HOLD:  if (out_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign out_valid    = (state == S_HOLD);
  assign out_value    = {sign_q, exp_q, sig_q};
  assign out_invalid  = inv_q;
  assign out_denormal = den_q;
  assign out_commit   = commit_q;
endmodule

// File: rtl/fpx_loader_chk.sv
`timescale 1ns/1ps
module fpx_loader_chk
  import fpx_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [XW-1:0] out_value,
  input logic          out_invalid,
  input logic          out_denormal,
  input logic          out_commit
);
  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_value)
      && $stable(out_invalid) && $stable(out_commit));

  // R10
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R7
  normalized_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_commit |-> out_value[63] || out_value[78:64] == '0);

  // R6
  quiet_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> out_value[78:64] == '1 && out_value[62]);

  // R9
  no_commit_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_commit |-> out_denormal);

  // R11
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid && in_ready);
endmodule

bind fp_ext_loader fpx_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_value(out_value), .out_invalid(out_invalid),
  .out_denormal(out_denormal), .out_commit(out_commit));

// File: tb/tb_fp_ext_loader.sv
`timescale 1ns/1ps
module tb_fp_ext_loader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_dbl = 1'b0, in_dnorm_mask = 1'b0, out_ready = 1'b1;
  logic [63:0] in_mem = '0;
  logic in_ready, out_valid, out_invalid, out_denormal, out_commit;
  logic [79:0] out_value;
  int checks = 0, fails = 0, vec = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fp_ext_loader dut (.*);

  task automatic chk(input bit ok, input string rq, input logic [82:0] act, input logic [82:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // expected {sign, exp15, sig64, invalid, denormal, commit}
  function automatic logic [82:0] model(input logic dbl, input logic [63:0] w,
                                        input logic mask, output int lat, output string rq);
    int fw, bias, emax, e, p, n;
    logic s, inv, den, cm;
    logic [63:0] f, xs;
    logic [14:0] xe;
    fw = dbl ? 52 : 23; bias = dbl ? 1023 : 127; emax = dbl ? 2047 : 255;
    s = dbl ? w[63] : w[31];
    e = dbl ? int'(w[62:52]) : int'(w[30:23]);
    f = dbl ? {12'd0, w[51:0]} : {41'd0, w[22:0]};
    inv = 0; den = 0; cm = 1; lat = 1; p = 0;
    if (e == 0 && f == 0) begin
      xe = 0; xs = 0; rq = "R4";
    end else if (e == emax) begin
      xe = 15'h7fff;
      if (f == 0) begin xs = 64'd1 << 63; rq = "R5"; end
      else begin
        xs = (64'h3 << 62) | (f << (63 - fw));
        inv = !f[fw-1];
        rq = inv ? "R6" : "R5";
      end
    end else if (e == 0) begin
      for (int i = 0; i < fw; i++) if (f[i]) p = i;
      n = fw - p; den = 1;
      if (mask) begin
        xe = 15'(16383 - (bias - 1) - n); xs = f << (63 - fw + n); lat = 1 + n; rq = "R7 R9";
      end else begin
        xe = 15'(16383 - (bias - 1)); xs = f << (63 - fw); cm = 0; rq = "R8 R9";
      end
    end else begin
      xe = 15'(e - bias + 16383);
      xs = (64'd1 << 63) | (f << (63 - fw));
      rq = dbl ? "R2" : "R1 R3";
    end
    return {s, xe, xs, inv, den, cm};
  endfunction

  task automatic run(input logic dbl, input logic [63:0] mem, input logic mask, input int stall);
    logic [82:0] exp, act, held;
    int lat, got, guard;
    string rq;
    exp = model(dbl, mem, mask, lat, rq);
    @(negedge clk);
    in_valid = 1; in_dbl = dbl; in_mem = mem; in_dnorm_mask = mask;
    out_ready = (stall == 0);
    guard = 0;
    while (!in_ready && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    in_valid = 0; in_mem = 64'hA5A5_5A5A_0F0F_F0F0;
    got = 1;
    while (!out_valid && got < 200) begin @(negedge clk); got++; end
    act = {out_value, out_invalid, out_denormal, out_commit};
    chk(act == exp, rq, act, exp);
    chk(got == lat, (lat == 1) ? "R11 latency" : "R7 latency", 83'(got), 83'(lat));
    if (stall > 0) begin
      held = act;
      for (int i = 0; i < stall; i++) begin
        @(negedge clk);
        chk(out_valid && {out_value, out_invalid, out_denormal, out_commit} == held,
            "R10 hold", {out_value, out_invalid, out_denormal, out_commit}, held);
      end
      out_ready = 1;
      @(negedge clk);
      chk(!out_valid && in_ready, "R11 release", {81'd0, out_valid, in_ready}, 83'd1);
    end
    vec++;
  endtask

  initial begin
    #(4ns * 190000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [22:0] sf [4];
    logic [51:0] df [4];
    sf[0] = 23'h0; sf[1] = 23'h400000; sf[2] = 23'h000001; sf[3] = 23'h2AAAAA;
    df[0] = 52'h0; df[1] = 52'h8_0000_0000_0000; df[2] = 52'h1; df[3] = 52'h5_5555_5555_5555;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!out_valid && in_ready, "R12 reset", {81'd0, out_valid, in_ready}, 83'd1);
    rst_n = 1;
    // single sweep: all exponents, several fractions, both signs, upper lanes garbage (R3)
    for (int e = 0; e < 256; e++)
      for (int k = 0; k < 4; k++)
        for (int s = 0; s < 2; s++)
          run(1'b0, {32'hDEAD_BEEF ^ 32'(e * 8 + k), 1'(s), 8'(e), sf[k]},
              1'((e + k) & 1), ((e * 8 + k * 2 + s) % 97 == 0) ? 3 : 0);
    // single denormals, every msb position, both mask settings
    for (int p = 0; p < 23; p++)
      for (int m = 0; m < 2; m++)
        run(1'b0, {32'h1234_5678, 1'(p & 1), 8'd0, (23'd1 << p) | ((23'd1 << p) - 23'd1) >> 1},
            1'(m), (p == 5) ? 2 : 0);
    // double sweep
    for (int e = 0; e < 2048; e += 73)
      for (int k = 0; k < 4; k++)
        run(1'b1, {1'(k & 1), 11'(e), df[k]}, 1'b1, 0);
    for (int j = 0; j < 6; j++)
      for (int k = 0; k < 4; k++) begin
        int ev;
        ev = (j == 0) ? 1 : (j == 1) ? 1022 : (j == 2) ? 1023 : (j == 3) ? 1024 : (j == 4) ? 2046 : 2047;
        run(1'b1, {1'(j & 1), 11'(ev), df[k]}, 1'b0, (k == 3) ? 2 : 0);
      end
    for (int p = 0; p < 52; p++)
      for (int m = 0; m < 2; m++)
        run(1'b1, {1'(m), 11'd0, (52'd1 << p) | 52'(p % 3)}, 1'(m), (p == 40) ? 4 : 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule